// File: doc/BRIEF.md
# Shared Tick Prescaler with Synchronized Restart

This block turns the system clock into one-cycle tick enables for one or more timer channels. A single 10-bit free-running divider is shared by all channels. Each channel has its own 3-bit select field that picks one of three things: no ticks, a tick on every cycle, or a tick once every 8, 32, 64, 128, 256 or 1024 cycles. When the external-input option is built in, the select field can instead pick the rising or the falling edge of an external pin. That pin is sampled on the system clock and does not pass through the divider.

Two control bits manage restarts of the shared divider. The restart bit clears the divider. Hardware drops the restart bit one cycle later, unless the hold bit is set. While the hold bit is set, the restart bit stays set and every channel that uses a divider tap is halted. Clearing the hold bit releases the divider, so all channels start counting in the same cycle. Both bits are written together through one write strobe.

Top module: `tick_prescaler`

## Requirements
- R1: A channel whose select field is 0 never asserts its tick.
- R2: Select value 1 asserts the tick on every cycle in which the restart bit is low.
- R3: A divider tap of N produces one single-cycle tick every N cycles. The first tick comes N cycles after the divider leaves restart, counting from the first cycle in which the divider is zero. With external input built in (EXT_EN=1), the codes 2,3,4,5 select 8, 64, 256 and 1024. Without it (EXT_EN=0), the codes 2 to 7 select 8, 32, 64, 128, 256 and 1024.
- R4: A write with restart=1 and hold=0 sets the restart bit for exactly one cycle. During that cycle the divider is cleared and no divider tick is produced. In the next cycle the divider value is zero.
- R5: While the hold bit is 1, the restart bit keeps its value and no divider tick is produced. A write with hold=0 and restart=0 clears both bits, so the divider is zero in the cycle right after the write.
- R6: With EXT_EN=1, code 7 ticks on the rising edge and code 6 on the falling edge of `ext_pin`. The pin passes through a two-flop synchronizer, so the tick is one cycle wide and appears two clock edges after the pin changes. External ticks are not affected by the restart or hold bits.
- R7: Channels that select the same divider tap tick in the same cycles.
- R8: System reset clears the divider, the restart bit and the hold bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csel | input | 3*NUM_CH | Select field per channel, channel c in bits [3c+2:3c] |
| ext_pin | input | 1 | External clock pin, asynchronous |
| ctl_we | input | 1 | Write strobe for the control bits |
| ctl_hold | input | 1 | Hold bit value written |
| ctl_restart | input | 1 | Restart bit value written |
| tick | output | NUM_CH | Per-channel one-cycle tick enable |
| hold_o | output | 1 | Current hold bit |
| restart_o | output | 1 | Current restart bit |

## Verification
The bench measures the cycle of the first tick after a self-clearing restart and after a release from hold. A divider cleared one cycle early or late shows up as a first-tick index that is off by one. Tap decoding is checked on both build variants. A wrong mask gives the wrong tick count over a fixed window, which the bench counts. During a held restart the bench looks for two faults: a divider tick that leaks through, or a restart bit that self-clears. It also checks that external edges are counted at the right latency during a held restart, since a design that gated them with the restart bit would lose them. A final check confirms that a system reset taken in the middle of a hold releases both control bits.

// File: rtl/presc_pkg.sv
package presc_pkg;

   localparam int CSEL_W = 3;

   localparam logic [CSEL_W-1:0] CS_OFF      = 3'd0;
   localparam logic [CSEL_W-1:0] CS_EVERY    = 3'd1;
   localparam logic [CSEL_W-1:0] CS_EXT_FALL = 3'd6;
   localparam logic [CSEL_W-1:0] CS_EXT_RISE = 3'd7;

   typedef enum logic [1:0] {
      SRC_OFF,
      SRC_DIV,
      SRC_FALL,
      SRC_RISE
   } tick_src_e;

   // log2 of the division factor chosen by a select code
   function automatic int tap_shift(logic [CSEL_W-1:0] code, bit ext_en);
      int sh;
      sh = 0;
      if (ext_en) begin
         case (code)
            3'd2:    sh = 3;
            3'd3:    sh = 6;
            3'd4:    sh = 8;
            3'd5:    sh = 10;
            default: sh = 0;
         endcase
      end else begin
         case (code)
            3'd2:    sh = 3;
            3'd3:    sh = 5;
            3'd4:    sh = 6;
            3'd5:    sh = 7;
            3'd6:    sh = 8;
            3'd7:    sh = 10;
            default: sh = 0;
         endcase
      end
      return sh;
   endfunction

   function automatic tick_src_e decode_src(logic [CSEL_W-1:0] code, bit ext_en);
      tick_src_e s;
      if (code == CS_OFF)                    s = SRC_OFF;
      else if (ext_en && code == CS_EXT_RISE) s = SRC_RISE;
      else if (ext_en && code == CS_EXT_FALL) s = SRC_FALL;
      else                                    s = SRC_DIV;
      return s;
   endfunction

endpackage

// File: rtl/presc_ctrl.sv
module presc_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic we,
   input  logic wr_hold,
   input  logic wr_restart,
   output logic hold_q,
   output logic restart_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q    <= 1'b0;
         restart_q <= 1'b0;
      end else if (we) begin
         hold_q <= wr_hold;
         if (wr_restart)
            restart_q <= 1'b1;
         else if (!wr_hold)
            restart_q <= 1'b0;
      end else if (restart_q && !hold_q) begin
         restart_q <= 1'b0;
      end
   end

endmodule

// File: rtl/presc_divider.sv
module presc_divider #(
   parameter int DIV_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   output logic [DIV_W-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (rst || clr)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/presc_edge.sv
module presc_edge #(
   parameter int SYNC_N = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic pin,
   output logic rise,
   output logic fall
);

   logic [SYNC_N:0] shreg;

   always_ff @(posedge clk) begin
      if (rst)
         shreg <= '0;
      else
         shreg <= {shreg[SYNC_N-1:0], pin};
   end

   assign rise =  shreg[SYNC_N-1] & ~shreg[SYNC_N];
   assign fall = ~shreg[SYNC_N-1] &  shreg[SYNC_N];

endmodule

// File: rtl/presc_tap.sv
module presc_tap
   import presc_pkg::*;
#(
   parameter int DIV_W  = 10,
   parameter bit EXT_EN = 1'b1
) (
   input  logic [CSEL_W-1:0] csel,
   input  logic [DIV_W-1:0]  cnt,
   input  logic              halt,
   input  logic              ext_rise,
   input  logic              ext_fall,
   output logic              tick
);

   logic [DIV_W-1:0] mask;
   tick_src_e        src;

   always_comb begin
      src  = decode_src(csel, EXT_EN);
      mask = {DIV_W{1'b1}} >> (DIV_W - tap_shift(csel, EXT_EN));
      unique case (src)
         SRC_OFF:  tick = 1'b0;
         SRC_DIV:  tick = !halt && ((cnt & mask) == mask);
         SRC_FALL: tick = ext_fall;
         SRC_RISE: tick = ext_rise;
         default:  tick = 1'b0;
      endcase
   end

endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler
   import presc_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DIV_W  = 10,
   parameter bit EXT_EN = 1'b1,
   parameter int SYNC_N = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NUM_CH*CSEL_W-1:0] csel,
   input  logic                     ext_pin,
   input  logic                     ctl_we,
   input  logic                     ctl_hold,
   input  logic                     ctl_restart,
   output logic [NUM_CH-1:0]        tick,
   output logic                     hold_o,
   output logic                     restart_o
);

   localparam int MIN_DIV_W = 10;

   generate
      if (DIV_W < MIN_DIV_W) begin : g_bad_w
         $error("DIV_W must cover the 1024 tap");
      end
      if (NUM_CH < 1) begin : g_bad_ch
         $error("NUM_CH must be at least one");
      end
      if (SYNC_N < 2) begin : g_bad_sync
         $error("SYNC_N must be at least two");
      end
   endgenerate

   logic [DIV_W-1:0] div_cnt;
   logic             ext_rise;
   logic             ext_fall;

   presc_ctrl u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .we         (ctl_we),
      .wr_hold    (ctl_hold),
      .wr_restart (ctl_restart),
      .hold_q     (hold_o),
      .restart_q  (restart_o)
   );

   presc_divider #(.DIV_W(DIV_W)) u_div (
      .clk (clk),
      .rst (rst),
      .clr (restart_o),
      .cnt (div_cnt)
   );

   generate
      if (EXT_EN) begin : g_ext
         presc_edge #(.SYNC_N(SYNC_N)) u_edge (
            .clk  (clk),
            .rst  (rst),
            .pin  (ext_pin),
            .rise (ext_rise),
            .fall (ext_fall)
         );
      end else begin : g_noext
         assign ext_rise = 1'b0;
         assign ext_fall = 1'b0;
      end

      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         presc_tap #(.DIV_W(DIV_W), .EXT_EN(EXT_EN)) u_tap (
            .csel     (csel[c*CSEL_W +: CSEL_W]),
            .cnt      (div_cnt),
            .halt     (restart_o),
            .ext_rise (ext_rise),
            .ext_fall (ext_fall),
            .tick     (tick[c])
         );
      end
   endgenerate

endmodule

// File: rtl/presc_checker.sv
module presc_checker #(
   parameter int NUM_CH = 2,
   parameter bit EXT_EN = 1'b1
) (
   input logic                clk,
   input logic                rst,
   input logic [NUM_CH*3-1:0] csel,
   input logic                ctl_we,
   input logic [NUM_CH-1:0]   tick,
   input logic                hold_o,
   input logic                restart_o
);

   // R4: restart drops by itself when not held and not rewritten
   a_r4_self_clear: assert property (@(posedge clk) disable iff (rst)
      (restart_o && !hold_o && !ctl_we) |=> !restart_o);

   // R5: hold keeps restart active
   a_r5_hold_keeps: assert property (@(posedge clk) disable iff (rst)
      (restart_o && hold_o && !ctl_we) |=> restart_o);

   // R8: reset leaves both control bits clear
   a_r8_reset_clear: assert property (@(posedge clk)
      rst |=> (!restart_o && !hold_o));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      // R1
      a_r1_off_silent: assert property (@(posedge clk) disable iff (rst)
         (csel[c*3 +: 3] == 3'd0) |-> !tick[c]);
      // R2
      a_r2_every_cycle: assert property (@(posedge clk) disable iff (rst)
         (csel[c*3 +: 3] == 3'd1 && !restart_o) |-> tick[c]);
      // R3: the 8 tap gives single-cycle pulses
      a_r3_div8_single: assert property (@(posedge clk) disable iff (rst)
         (csel[c*3 +: 3] == 3'd2 && tick[c]) |=> (!tick[c] || csel[c*3 +: 3] != 3'd2));
      // R5: no divider tick while restart is active
      a_r5_halted: assert property (@(posedge clk) disable iff (rst)
         (restart_o && csel[c*3 +: 3] != 3'd0 && (!EXT_EN || csel[c*3 +: 3] < 3'd6)) |-> !tick[c]);
      // R6: external ticks are one cycle wide
      a_r6_ext_single: assert property (@(posedge clk) disable iff (rst)
         (EXT_EN && csel[c*3 +: 3] >= 3'd6 && tick[c]) |=> (!tick[c] || $changed(csel[c*3 +: 3])));
   end

endmodule

bind tick_prescaler presc_checker #(.NUM_CH(NUM_CH), .EXT_EN(EXT_EN)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .csel      (csel),
   .ctl_we    (ctl_we),
   .tick      (tick),
   .hold_o    (hold_o),
   .restart_o (restart_o)
);

// File: tb/sim_tick_prescaler.sv
module sim_tick_prescaler;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] cs0 = 3'd0;
   logic [2:0] cs1 = 3'd0;
   logic [2:0] csu = 3'd0;
   logic       ext_pin = 1'b0;
   logic       ctl_we = 1'b0;
   logic       ctl_hold = 1'b0;
   logic       ctl_restart = 1'b0;
   logic [1:0] tick;
   logic [0:0] tick_u;
   logic       hold_o, restart_o, hold_u, restart_u;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   int nt [3];
   int ft [3];
   int mism;

   always #5 clk = ~clk;

   tick_prescaler u0 (
      .clk(clk), .rst(rst), .csel({cs1, cs0}), .ext_pin(ext_pin),
      .ctl_we(ctl_we), .ctl_hold(ctl_hold), .ctl_restart(ctl_restart),
      .tick(tick), .hold_o(hold_o), .restart_o(restart_o)
   );

   tick_prescaler #(.NUM_CH(1), .EXT_EN(1'b0)) u1 (
      .clk(clk), .rst(rst), .csel(csu), .ext_pin(ext_pin),
      .ctl_we(ctl_we), .ctl_hold(ctl_hold), .ctl_restart(ctl_restart),
      .tick(tick_u), .hold_o(hold_u), .restart_o(restart_u)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // sample n cycles at falling edges; optionally toggle ext_pin every per samples
   task automatic run(int n, int per);
      logic [2:0] tk;
      for (int c = 0; c < 3; c++) begin
         nt[c] = 0;
         ft[c] = -1;
      end
      mism = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tk = {tick_u[0], tick};
         for (int c = 0; c < 3; c++) begin
            if (tk[c]) begin
               if (nt[c] == 0) ft[c] = i;
               nt[c]++;
            end
         end
         if (tick[0] != tick[1]) mism++;
         if (per > 0 && (i % per) == per - 1) ext_pin = ~ext_pin;
      end
   endtask

   // one-cycle control write; returns restart bit and ch0 tick in the cycle after it
   task automatic wr_ctl(logic h, logic r, output logic rs_after, output logic tk_after);
      @(negedge clk);
      ctl_we = 1'b1;
      ctl_hold = h;
      ctl_restart = r;
      @(negedge clk);
      ctl_we = 1'b0;
      ctl_hold = 1'b0;
      ctl_restart = 1'b0;
      rs_after = restart_o;
      tk_after = tick[0];
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R8", "restart after reset", int'(restart_o), 0);
      chk("R8", "hold after reset", int'(hold_o), 0);
      chk("R1", "tick with select 0 at reset", int'(tick), 0);
   endtask

   task automatic t_off;
      cs0 = 3'd0; cs1 = 3'd0;
      run(50, 0);
      chk("R1", "ticks ch0 select 0", nt[0], 0);
      chk("R1", "ticks ch1 select 0", nt[1], 0);
   endtask

   task automatic t_every;
      cs0 = 3'd1;
      run(20, 0);
      chk("R2", "ticks select 1 over 20", nt[0], 20);
   endtask

   task automatic t_restart_pulse;
      logic rs, tk;
      cs0 = 3'd1;
      wr_ctl(1'b0, 1'b1, rs, tk);
      chk("R4", "restart bit in cycle after write", int'(rs), 1);
      chk("R4", "select 1 tick during restart", int'(tk), 0);
      run(20, 0);
      chk("R4", "restart bit cleared", int'(restart_o), 0);
      chk("R4", "first select 1 tick index", ft[0], 0);
      chk("R2", "ticks after restart", nt[0], 20);
   endtask

   task automatic t_div_small;
      logic rs, tk;
      cs0 = 3'd2; cs1 = 3'd3;
      wr_ctl(1'b0, 1'b1, rs, tk);
      run(128, 0);
      chk("R3", "div8 first tick", ft[0], 7);
      chk("R3", "div8 count", nt[0], 16);
      chk("R3", "div64 first tick", ft[1], 63);
      chk("R3", "div64 count", nt[1], 2);
   endtask

   task automatic t_div_large;
      logic rs, tk;
      cs0 = 3'd4; cs1 = 3'd5;
      wr_ctl(1'b0, 1'b1, rs, tk);
      run(2048, 0);
      chk("R3", "div256 first tick", ft[0], 255);
      chk("R3", "div256 count", nt[0], 8);
      chk("R3", "div1024 first tick", ft[1], 1023);
      chk("R3", "div1024 count", nt[1], 2);
   endtask

   task automatic t_shared;
      cs0 = 3'd2; cs1 = 3'd2;
      run(64, 0);
      chk("R7", "same-tap mismatched cycles", mism, 0);
      chk("R7", "same-tap ch1 count", nt[1], 8);
   endtask

   task automatic t_hold_release;
      logic rs, tk;
      cs0 = 3'd1; cs1 = 3'd2;
      wr_ctl(1'b1, 1'b1, rs, tk);
      run(40, 0);
      chk("R5", "restart held", int'(restart_o), 1);
      chk("R5", "hold bit", int'(hold_o), 1);
      chk("R5", "select 1 ticks while held", nt[0], 0);
      chk("R5", "div8 ticks while held", nt[1], 0);
      cs0 = 3'd2; cs1 = 3'd3;
      wr_ctl(1'b0, 1'b0, rs, tk);
      chk("R5", "restart after release", int'(rs), 0);
      run(64, 0);
      chk("R5", "div8 first tick after release", ft[0], 6);
      chk("R5", "div64 first tick after release", ft[1], 62);
   endtask

   task automatic t_ext;
      logic rs, tk;
      cs0 = 3'd7; cs1 = 3'd6;
      wr_ctl(1'b1, 1'b1, rs, tk);
      run(80, 4);
      chk("R6", "rising ticks", nt[0], 10);
      chk("R6", "first rising tick latency", ft[0], 5);
      chk("R6", "falling ticks", nt[1], 9);
      chk("R6", "first falling tick latency", ft[1], 9);
      chk("R6", "restart still held", int'(restart_o), 1);
      cs0 = 3'd0; cs1 = 3'd0;
      wr_ctl(1'b0, 1'b0, rs, tk);
   endtask

   task automatic t_variant;
      logic rs, tk;
      csu = 3'd3;
      wr_ctl(1'b0, 1'b1, rs, tk);
      run(256, 0);
      chk("R3", "EXT_EN=0 div32 first tick", ft[2], 31);
      chk("R3", "EXT_EN=0 div32 count", nt[2], 8);
      csu = 3'd5;
      wr_ctl(1'b0, 1'b1, rs, tk);
      run(256, 0);
      chk("R3", "EXT_EN=0 div128 first tick", ft[2], 127);
      chk("R3", "EXT_EN=0 div128 count", nt[2], 2);
   endtask

   task automatic t_reset_in_hold;
      logic rs, tk;
      cs0 = 3'd1;
      wr_ctl(1'b1, 1'b1, rs, tk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      run(10, 0);
      chk("R8", "hold after mid-hold reset", int'(hold_o), 0);
      chk("R8", "restart after mid-hold reset", int'(restart_o), 0);
      chk("R8", "ticks resume after reset", nt[0], 10);
   endtask

   initial begin
      t_reset();
      t_off();
      t_every();
      t_restart_pulse();
      t_div_small();
      t_div_large();
      t_shared();
      t_hold_release();
      t_ext();
      t_variant();
      t_reset_in_hold();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule